// File: doc/BRIEF.md
# Redundant Dual-Channel User Permit Combiner

This block gathers the permit lines of a set of user systems and turns them into one permit per beam. Every user drives two redundant permit lines, A and B, and the block keeps two fully separate evaluation paths, one per line. Each path delivers its own beam-1 and beam-2 result. A beam permit is granted only when both paths agree that every contributing input is healthy. The final permit for each beam drives that beam's loop-cut decision. The two beams never influence each other, except that an input shared by both beams removes both permits at once.

Inputs sit in three fixed groups: beam-1-only, shared, and beam-2-only. Each input has a mask bit. A mask bit takes effect only while both registered copies of the safe-beam flag report safe. The safe flag comes out of reset as unsafe. For diagnosis the block also provides four things: registered copies of every A and B line, a sticky fault flag per input when A and B disagree for too long, and, for each beam, the index of the first input that removed a granted permit. A clear command resets the fault flags and the first-drop records.

Top module: `permit_combiner`

## Requirements
- R1: Inputs are grouped by index: 0 to N_B1-1 feed beam 1 only, the next N_SH feed both beams, and the last N_B2 feed beam 2 only. A beam-2-only input never changes a beam-1 output, and a beam-1-only input never changes a beam-2 output.
- R2: For each beam the A-path output becomes 1 one cycle after every assigned input's A line is 1 or effectively masked, and otherwise becomes 0. The B-path output follows the same rule on the B lines. The final beam permit is 1 only when both path outputs are 1.
- R3: A shared input whose line drops, when not effectively masked, removes both beam permits in the same cycle.
- R4: A mask bit is effective only while both registered safe copies are 1. Those copies are the safe inputs sampled at the previous edge. When the block is not safe, every mask bit is ignored.
- R5: `safe_o` is 1 only when both redundant safe copies, each registered from its own input, are 1.
- R6: During reset all permits, `safe_o`, the discrepancy flags, the readout copies and the first-drop valid flags are 0, and the first-drop indices are 0.
- R7: When an input's A and B lines differ on LIM consecutive sampled edges, its discrepancy flag is 1 after the LIM-th edge. LIM-1 edges of disagreement are not enough. The mask plays no part in this, and the flag stays set until a clear.
- R8: When a beam's final permit is 1 and an assigned input fails on either line, the lowest failing index is recorded and marked valid. The record is then held, and later drops do not change it until a clear.
- R9: `clr_i` sampled 1 zeroes all discrepancy flags and both first-drop records on that edge. It wins over a set in the same cycle.
- R10: `perm_state_a_o` and `perm_state_b_o` show the A and B lines sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| perm_a_i | input | N_IN | A permit line per input |
| perm_b_i | input | N_IN | B permit line per input |
| mask_i | input | N_IN | Mask request per input |
| safe_a_i | input | 1 | Safe-beam flag, copy A |
| safe_b_i | input | 1 | Safe-beam flag, copy B |
| clr_i | input | 1 | Clear discrepancy flags and first-drop records |
| b1_perm_a_o | output | 1 | Beam-1 A-path result |
| b1_perm_b_o | output | 1 | Beam-1 B-path result |
| b1_perm_o | output | 1 | Beam-1 final permit |
| b2_perm_a_o | output | 1 | Beam-2 A-path result |
| b2_perm_b_o | output | 1 | Beam-2 B-path result |
| b2_perm_o | output | 1 | Beam-2 final permit |
| safe_o | output | 1 | Agreed safe-beam state |
| perm_state_a_o | output | N_IN | Registered A lines |
| perm_state_b_o | output | N_IN | Registered B lines |
| disc_fault_o | output | N_IN | Sticky A/B discrepancy flags |
| b1_first_vld_o | output | 1 | Beam-1 first-drop record valid |
| b1_first_idx_o | output | IW | Beam-1 first-drop input index |
| b2_first_vld_o | output | 1 | Beam-2 first-drop record valid |
| b2_first_idx_o | output | IW | Beam-2 first-drop input index |

## Verification
The bench builds the block with its default groups of 6, 8 and 6 inputs and a discrepancy limit of 4 cycles. This makes all twenty indices, both group boundaries and the limit edge reachable within a few cycles each. Since the limit is small, directed runs of three and four disagreeing cycles land exactly on the threshold. Random stimulus also produces short mismatches that restart the counter. Mixed safe states exercise masks that are ignored, masks that are honoured, and the one-cycle delay between a safe change and its effect.

// File: rtl/permit_pkg.sv
package permit_pkg;

    typedef enum logic [1:0] {
        GRP_BEAM1  = 2'd0,
        GRP_SHARED = 2'd1,
        GRP_BEAM2  = 2'd2
    } grp_e;

    // Group membership by index: beam-1-only, shared, then beam-2-only.
    function automatic grp_e group_of(input int idx, input int n_b1, input int n_sh);
        if (idx < n_b1)             return GRP_BEAM1;
        else if (idx < n_b1 + n_sh) return GRP_SHARED;
        else                        return GRP_BEAM2;
    endfunction

    function automatic logic feeds_beam(input grp_e g, input int beam);
        if (beam == 0) return (g != GRP_BEAM2);
        else           return (g != GRP_BEAM1);
    endfunction

endpackage

// File: rtl/permit_path.sv
module permit_path
    import permit_pkg::*;
#(
    parameter int N_B1 = 6,
    parameter int N_SH = 8,
    parameter int N_B2 = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_B1+N_SH+N_B2-1:0] perm_i,
    input  logic [N_B1+N_SH+N_B2-1:0] ign_i,
    output logic [N_B1+N_SH+N_B2-1:0] fail_o,
    output logic [N_B1+N_SH+N_B2-1:0] state_o,
    output logic                b1_ok_o,
    output logic                b2_ok_o
);
    localparam int N_IN = N_B1 + N_SH + N_B2;

    typedef struct packed {
        logic [N_IN-1:0] state;
        logic            b1_ok;
        logic            b2_ok;
    } path_t;

    path_t path_d, path_q;
    logic [N_IN-1:0] sel1, sel2;

    for (genvar g = 0; g < N_IN; g++) begin : g_sel
        assign sel1[g] = feeds_beam(group_of(g, N_B1, N_SH), 0);
        assign sel2[g] = feeds_beam(group_of(g, N_B1, N_SH), 1);
    end

    assign fail_o = ~perm_i & ~ign_i;

    always_comb begin
        path_d       = path_q;
        path_d.state = perm_i;
        path_d.b1_ok = ~|(fail_o & sel1);
        path_d.b2_ok = ~|(fail_o & sel2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) path_q <= '0;
        else        path_q <= path_d;
    end

    assign state_o = path_q.state;
    assign b1_ok_o = path_q.b1_ok;
    assign b2_ok_o = path_q.b2_ok;
endmodule

// File: rtl/disc_monitor.sv
module disc_monitor #(
    parameter int N_IN = 20,
    parameter int LIM  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] a_i,
    input  logic [N_IN-1:0] b_i,
    input  logic            clr_i,
    output logic [N_IN-1:0] fault_o
);
    localparam int CW = $clog2(LIM) + 1;
    localparam logic [CW-1:0] TOP = CW'(LIM - 1);

    typedef struct packed {
        logic [N_IN-1:0][CW-1:0] cnt;
        logic [N_IN-1:0]         fault;
    } disc_t;

    disc_t disc_d, disc_q;

    always_comb begin
        disc_d = disc_q;
        for (int i = 0; i < N_IN; i++) begin
            if (a_i[i] != b_i[i]) begin
                if (disc_q.cnt[i] == TOP) disc_d.fault[i] = 1'b1;
                else                      disc_d.cnt[i]   = disc_q.cnt[i] + 1'b1;
            end else begin
                disc_d.cnt[i] = '0;
            end
        end
        if (clr_i) disc_d.fault = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) disc_q <= '0;
        else        disc_q <= disc_d;
    end

    assign fault_o = disc_q.fault;
endmodule

// File: rtl/first_drop.sv
module first_drop #(
    parameter int N_IN = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    perm_i,
    input  logic [N_IN-1:0]         fail_i,
    input  logic                    clr_i,
    output logic                    vld_o,
    output logic [$clog2(N_IN)-1:0] idx_o
);
    localparam int IW = $clog2(N_IN);

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
    } rec_t;

    rec_t rec_d, rec_q;
    logic [IW-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (fail_i[i]) low_idx = IW'(i);
        end
    end

    always_comb begin
        rec_d = rec_q;
        if (clr_i) begin
            rec_d = '0;
        end else if (!rec_q.vld && perm_i && |fail_i) begin
            rec_d.vld = 1'b1;
            rec_d.idx = low_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign vld_o = rec_q.vld;
    assign idx_o = rec_q.idx;
endmodule

// File: rtl/permit_combiner.sv
module permit_combiner
    import permit_pkg::*;
#(
    parameter int N_B1 = 6,
    parameter int N_SH = 8,
    parameter int N_B2 = 6,
    parameter int LIM  = 4,
    localparam int N_IN = N_B1 + N_SH + N_B2,
    localparam int IW   = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] perm_a_i,
    input  logic [N_IN-1:0] perm_b_i,
    input  logic [N_IN-1:0] mask_i,
    input  logic            safe_a_i,
    input  logic            safe_b_i,
    input  logic            clr_i,
    output logic            b1_perm_a_o,
    output logic            b1_perm_b_o,
    output logic            b1_perm_o,
    output logic            b2_perm_a_o,
    output logic            b2_perm_b_o,
    output logic            b2_perm_o,
    output logic            safe_o,
    output logic [N_IN-1:0] perm_state_a_o,
    output logic [N_IN-1:0] perm_state_b_o,
    output logic [N_IN-1:0] disc_fault_o,
    output logic            b1_first_vld_o,
    output logic [IW-1:0]   b1_first_idx_o,
    output logic            b2_first_vld_o,
    output logic [IW-1:0]   b2_first_idx_o
);
    typedef struct packed {
        logic cp_a;
        logic cp_b;
    } safe_t;

    safe_t safe_d, safe_q;

    always_comb begin
        safe_d      = safe_q;
        safe_d.cp_a = safe_a_i;
        safe_d.cp_b = safe_b_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) safe_q <= '0;
        else        safe_q <= safe_d;
    end

    assign safe_o = safe_q.cp_a & safe_q.cp_b;

    logic [N_IN-1:0]       ign;
    logic [1:0][N_IN-1:0]  line, fail_ch, state_ch;
    logic [1:0]            ok1, ok2, fin;
    logic [1:0][N_IN-1:0]  beam_sel, beam_fail;
    logic [1:0]            fd_vld;
    logic [1:0][IW-1:0]    fd_idx;

    assign ign     = mask_i & {N_IN{safe_o}};
    assign line[0] = perm_a_i;
    assign line[1] = perm_b_i;

    // Separate A and B evaluation paths; no sharing between them.
    for (genvar c = 0; c < 2; c++) begin : g_chan
        permit_path #(.N_B1(N_B1), .N_SH(N_SH), .N_B2(N_B2)) u_path (
            .clk     (clk),
            .rst_n   (rst_n),
            .perm_i  (line[c]),
            .ign_i   (ign),
            .fail_o  (fail_ch[c]),
            .state_o (state_ch[c]),
            .b1_ok_o (ok1[c]),
            .b2_ok_o (ok2[c])
        );
    end

    assign fin[0] = ok1[0] & ok1[1];
    assign fin[1] = ok2[0] & ok2[1];

    for (genvar bm = 0; bm < 2; bm++) begin : g_beam
        for (genvar g = 0; g < N_IN; g++) begin : g_bit
            assign beam_sel[bm][g] = feeds_beam(group_of(g, N_B1, N_SH), bm);
        end
        assign beam_fail[bm] = (fail_ch[0] | fail_ch[1]) & beam_sel[bm];

        first_drop #(.N_IN(N_IN)) u_first (
            .clk    (clk),
            .rst_n  (rst_n),
            .perm_i (fin[bm]),
            .fail_i (beam_fail[bm]),
            .clr_i  (clr_i),
            .vld_o  (fd_vld[bm]),
            .idx_o  (fd_idx[bm])
        );
    end

    disc_monitor #(.N_IN(N_IN), .LIM(LIM)) u_disc (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (perm_a_i),
        .b_i     (perm_b_i),
        .clr_i   (clr_i),
        .fault_o (disc_fault_o)
    );

    assign b1_perm_a_o    = ok1[0];
    assign b1_perm_b_o    = ok1[1];
    assign b1_perm_o      = fin[0];
    assign b2_perm_a_o    = ok2[0];
    assign b2_perm_b_o    = ok2[1];
    assign b2_perm_o      = fin[1];
    assign perm_state_a_o = state_ch[0];
    assign perm_state_b_o = state_ch[1];
    assign b1_first_vld_o = fd_vld[0];
    assign b1_first_idx_o = fd_idx[0];
    assign b2_first_vld_o = fd_vld[1];
    assign b2_first_idx_o = fd_idx[1];
endmodule

// File: rtl/permit_combiner_chk.sv
module permit_combiner_chk #(
    parameter int N_B1 = 6,
    parameter int N_SH = 8,
    parameter int N_B2 = 6,
    localparam int N_IN = N_B1 + N_SH + N_B2,
    localparam int IW   = $clog2(N_IN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] perm_a_i,
    input logic [N_IN-1:0] perm_b_i,
    input logic [N_IN-1:0] mask_i,
    input logic            clr_i,
    input logic            safe_o,
    input logic            b1_perm_a_o,
    input logic            b2_perm_a_o,
    input logic            b2_perm_b_o,
    input logic            b2_perm_o,
    input logic [N_IN-1:0] disc_fault_o,
    input logic            b1_first_vld_o,
    input logic [IW-1:0]   b1_first_idx_o
);
    // R4: an unsafe block ignores masks, so a dropped beam-1 line cuts the A path
    a_r4_mask_ignored_unsafe: assert property (@(posedge clk) disable iff (!rst_n)
        (!safe_o && !perm_a_i[0]) |=> !b1_perm_a_o);

    // R3: a shared input cuts both beams together
    a_r3_shared_cuts_both: assert property (@(posedge clk) disable iff (!rst_n)
        (!perm_a_i[N_B1] && !(safe_o && mask_i[N_B1])) |=> (!b1_perm_a_o && !b2_perm_a_o));

    // R2: a B-line drop removes the B path and the final permit
    a_r2_b_path_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (!perm_b_i[N_IN-1] && !(safe_o && mask_i[N_IN-1])) |=> (!b2_perm_b_o && !b2_perm_o));

    // R8: a recorded first drop is held until cleared
    a_r8_first_held: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_first_vld_o && !clr_i) |=> (b1_first_vld_o && $stable(b1_first_idx_o)));

    // R7: discrepancy flags are sticky without a clear
    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((disc_fault_o & $past(disc_fault_o)) == $past(disc_fault_o)));

    // R9: clear empties the flags and the record
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (disc_fault_o == '0 && !b1_first_vld_o));
endmodule

bind permit_combiner permit_combiner_chk #(.N_B1(N_B1), .N_SH(N_SH), .N_B2(N_B2)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .perm_a_i       (perm_a_i),
    .perm_b_i       (perm_b_i),
    .mask_i         (mask_i),
    .clr_i          (clr_i),
    .safe_o         (safe_o),
    .b1_perm_a_o    (b1_perm_a_o),
    .b2_perm_a_o    (b2_perm_a_o),
    .b2_perm_b_o    (b2_perm_b_o),
    .b2_perm_o      (b2_perm_o),
    .disc_fault_o   (disc_fault_o),
    .b1_first_vld_o (b1_first_vld_o),
    .b1_first_idx_o (b1_first_idx_o)
);

// File: tb/tb_permit_combiner.sv
module tb_permit_combiner;
    localparam int N_B1 = 6, N_SH = 8, N_B2 = 6, LIM = 4;
    localparam int N  = N_B1 + N_SH + N_B2;
    localparam int IW = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] pa = '0, pb = '0, mask = '0;
    logic sa = 1'b0, sb = 1'b0, clr = 1'b0;
    logic b1a, b1b, b1, b2a, b2b, b2, safe;
    logic [N-1:0] sta, stb, flt;
    logic v1, v2;
    logic [IW-1:0] i1, i2;

    int vectors = 0, errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    permit_combiner #(.N_B1(N_B1), .N_SH(N_SH), .N_B2(N_B2), .LIM(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .perm_a_i(pa), .perm_b_i(pb), .mask_i(mask),
        .safe_a_i(sa), .safe_b_i(sb), .clr_i(clr),
        .b1_perm_a_o(b1a), .b1_perm_b_o(b1b), .b1_perm_o(b1),
        .b2_perm_a_o(b2a), .b2_perm_b_o(b2b), .b2_perm_o(b2),
        .safe_o(safe), .perm_state_a_o(sta), .perm_state_b_o(stb),
        .disc_fault_o(flt), .b1_first_vld_o(v1), .b1_first_idx_o(i1),
        .b2_first_vld_o(v2), .b2_first_idx_o(i2)
    );

    // Reference model state
    logic m_sa, m_sb;
    logic [1:0] m_ok1, m_ok2, m_vld;
    logic [N-1:0] m_sta, m_stb, m_flt;
    int m_cnt [N];
    int m_idx [2];

    function automatic logic [N-1:0] sel_of(input int beam);
        logic [N-1:0] s;
        for (int i = 0; i < N; i++)
            s[i] = (beam == 0) ? (i < N_B1 + N_SH) : (i >= N_B1);
        return s;
    endfunction

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic model_reset();
        m_sa = 0; m_sb = 0; m_ok1 = 0; m_ok2 = 0; m_vld = 0;
        m_sta = 0; m_stb = 0; m_flt = 0;
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
        m_idx[0] = 0; m_idx[1] = 0;
    endtask

    task automatic model_step();
        logic [N-1:0] eff, fa, fb, fl;
        logic [1:0] fin;
        eff = mask & {N{m_sa & m_sb}};
        fa = ~pa & ~eff;
        fb = ~pb & ~eff;
        fin[0] = m_ok1[0] & m_ok1[1];
        fin[1] = m_ok2[0] & m_ok2[1];
        for (int bm = 0; bm < 2; bm++) begin
            fl = (fa | fb) & sel_of(bm);
            if (clr) begin
                m_vld[bm] = 0; m_idx[bm] = 0;
            end else if (!m_vld[bm] && fin[bm] && fl != 0) begin
                m_vld[bm] = 1; m_idx[bm] = lowest(fl);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (pa[i] != pb[i]) begin
                if (m_cnt[i] == LIM - 1) m_flt[i] = 1'b1;
                else m_cnt[i]++;
            end else m_cnt[i] = 0;
        end
        if (clr) m_flt = '0;
        m_ok1[0] = ((fa & sel_of(0)) == 0);
        m_ok1[1] = ((fb & sel_of(0)) == 0);
        m_ok2[0] = ((fa & sel_of(1)) == 0);
        m_ok2[1] = ((fb & sel_of(1)) == 0);
        m_sta = pa; m_stb = pb;
        m_sa = sa; m_sb = sb;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2", "b1 A path", 32'(b1a), 32'(m_ok1[0]));
        chk("R2", "b1 B path", 32'(b1b), 32'(m_ok1[1]));
        chk("R2", "b1 final", 32'(b1), 32'(m_ok1[0] & m_ok1[1]));
        chk("R2", "b2 A path", 32'(b2a), 32'(m_ok2[0]));
        chk("R2", "b2 B path", 32'(b2b), 32'(m_ok2[1]));
        chk("R2", "b2 final", 32'(b2), 32'(m_ok2[0] & m_ok2[1]));
        chk("R5", "safe", 32'(safe), 32'(m_sa & m_sb));
        chk("R10", "state A", 32'(sta), 32'(m_sta));
        chk("R10", "state B", 32'(stb), 32'(m_stb));
        chk("R7", "faults", 32'(flt), 32'(m_flt));
        chk("R8", "b1 first vld", 32'(v1), 32'(m_vld[0]));
        chk("R8", "b1 first idx", 32'(i1), 32'(m_idx[0]));
        chk("R8", "b2 first vld", 32'(v2), 32'(m_vld[1]));
        chk("R8", "b2 first idx", 32'(i2), 32'(m_idx[1]));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic all_good();
        pa = '1; pb = '1; mask = '0; clr = 0; sa = 1; sb = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20250412);
        model_reset();
        repeat (3) @(negedge clk);
        // R6: reset state
        chk("R6", "b1 permit", 32'(b1), 0);
        chk("R6", "b2 permit", 32'(b2), 0);
        chk("R6", "safe", 32'(safe), 0);
        chk("R6", "faults", 32'(flt), 0);
        chk("R6", "first vld", 32'({v1, v2}), 0);
        compare_all();
        rst_n = 1'b1;

        all_good();
        repeat (3) cycle();
        chk("R2", "both permits granted", 32'({b1, b2}), 32'h3);

        // R1: beam-2-only input leaves beam 1 alone
        pa[15] = 0; pb[15] = 0; cycle();
        chk("R1", "b1 after beam2-only drop", 32'(b1), 1);
        chk("R1", "b2 after beam2-only drop", 32'(b2), 0);
        all_good(); cycle();
        // R1: beam-1-only input leaves beam 2 alone
        pb[1] = 0; cycle();
        chk("R1", "b2 after beam1-only drop", 32'(b2), 1);
        chk("R1", "b1 B path after drop", 32'(b1b), 0);
        chk("R8", "b1 first idx", 32'(i1), 1);
        all_good(); cycle();
        clr = 1; cycle(); clr = 0; cycle();

        // R3: shared input cuts both
        pa[8] = 0; pb[8] = 0; pa[12] = 0; cycle();
        chk("R3", "b1 after shared drop", 32'(b1), 0);
        chk("R3", "b2 after shared drop", 32'(b2), 0);
        chk("R8", "b1 lowest first idx", 32'(i1), 8);
        all_good(); cycle();

        // R4: masks honoured while safe, ignored one cycle after safe drops
        mask[2] = 1; pa[2] = 0; pb[2] = 0; cycle();
        chk("R4", "masked drop while safe", 32'(b1), 1);
        sb = 0; cycle();
        chk("R4", "safe copy seen next edge", 32'(b1), 1);
        cycle();
        chk("R4", "mask ignored when unsafe", 32'(b1), 0);
        chk("R5", "one copy unsafe", 32'(safe), 0);
        all_good(); repeat (2) cycle();

        // R9: clear
        clr = 1; cycle(); clr = 0;
        chk("R9", "first vld cleared", 32'({v1, v2}), 0);

        // R7: LIM-1 cycles of mismatch do not latch
        pa[3] = 0; mask[3] = 1;
        repeat (LIM - 1) cycle();
        pa[3] = 1; cycle();
        chk("R7", "no fault at LIM-1", 32'(flt[3]), 0);
        pa[3] = 0;
        repeat (LIM) cycle();
        chk("R7", "fault at LIM", 32'(flt[3]), 1);
        all_good(); repeat (2) cycle();
        chk("R7", "fault sticky", 32'(flt[3]), 1);
        // R9: clear wins while mismatch persists
        pb[4] = 0; repeat (LIM) cycle();
        clr = 1; cycle();
        chk("R9", "faults cleared", 32'(flt), 0);
        clr = 0; all_good(); cycle();

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < N; i++) begin
                pa[i] = ($urandom_range(39) != 0);
                pb[i] = ($urandom_range(59) == 0) ? ~pa[i] : pa[i];
            end
            mask = N'($urandom) & N'($urandom);
            sa = ($urandom_range(5) != 0);
            sb = ($urandom_range(5) != 0);
            clr = ($urandom_range(49) == 0);
            if ($urandom_range(3) == 0) begin pa = '1; pb = '1; end
            cycle();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule